// File: doc/BRIEF.md
# Bounded Home-Memory Reservation Tracker

This block sits beside a home memory controller. It keeps the reservations that back load-linked / store-conditional pairs when those operations run at the memory rather than in a cache. Each memory block gets a fixed set of four reservation slots. Each slot holds a valid flag and a requester ID. This replaces a per-processor bit vector for every block.

Each cycle the block can take one ordinary-write event, one store-conditional event and one load-linked event. Each event carries a block index, and the two reservation events also carry a requester ID. One cycle later it reports whether the store-conditional found a reservation and whether the load-linked was given one. A load-linked that arrives when its block already has four other holders is refused. The requester can then fail its store-conditional locally without sending it. Data storage, transport and coherence are handled elsewhere. Block indices presented on the ports are assumed to be below `NUM_BLOCKS`.

Top module: `resv_tracker`

## Requirements
- R1: Each request gets its response on the clock edge that samples it. `sc_rsp_vld` equals the `sc_vld` of the previous cycle, and `ll_rsp_vld` equals the `ll_vld` of the previous cycle. When a response valid flag is low, the matching result bit is low.
- R2: A load-linked to a block with a free slot is granted (`ll_rsp_granted` = 1). It records the requester as a holder on that block.
- R3: A block holds at most four distinct requesters. A load-linked from a fifth distinct requester is refused (`ll_rsp_granted` = 0). It leaves the block's existing reservations intact, and a later store-conditional from the refused requester fails.
- R4: A load-linked from a requester that already holds a reservation on the block is granted and takes no further slot.
- R5: A store-conditional succeeds (`sc_rsp_ok` = 1) if and only if its requester holds a reservation on its block.
- R6: A successful store-conditional removes every reservation on its block. A failed one changes no reservation.
- R7: An ordinary write removes every reservation on its block and leaves all other blocks untouched.
- R8: Events in the same cycle take effect in a fixed order: the write first, then the store-conditional, then the load-linked. A store-conditional that shares a cycle and block with a write fails. A load-linked that shares a cycle and block with a write or a successful store-conditional is granted.
- R9: While `rst_n` is low at a clock edge, every reservation is cleared and all response outputs are low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_vld | input | 1 | Ordinary write event present |
| wr_blk | input | BLK_W | Block index of the write |
| sc_vld | input | 1 | Store-conditional event present |
| sc_blk | input | BLK_W | Block index of the store-conditional |
| sc_id | input | ID_W | Requester issuing the store-conditional |
| ll_vld | input | 1 | Load-linked event present |
| ll_blk | input | BLK_W | Block index of the load-linked |
| ll_id | input | ID_W | Requester issuing the load-linked |
| sc_rsp_vld | output | 1 | Store-conditional response present |
| sc_rsp_ok | output | 1 | Store-conditional found a reservation |
| ll_rsp_vld | output | 1 | Load-linked response present |
| ll_rsp_granted | output | 1 | Load-linked obtained or kept a slot |

## Verification
The hardest situation to reach is a full block: four distinct holders, then a further distinct requester, while a repeat load-linked from a holder must still be granted. Random stimulus seldom keeps a block untouched by writes and successful store-conditionals for that long. Directed sequences therefore fill blocks deliberately. The random phase then confines events to three blocks and six requester IDs, and it keeps writes rare, so that saturation and refusals recur. Same-cycle collisions of a write, a store-conditional and a load-linked on one block are also built directly, because random traffic lines up all three on one block only occasionally.

// File: rtl/resv_pkg.sv
// Shared constants and helpers for the reservation tracker.
// Assumes: slot count is fixed per block and small enough for a flat priority pick.
package resv_pkg;

    localparam int RSV_SLOTS = 4;

    // One-hot of the lowest set bit, zero when none is set.
    function automatic logic [RSV_SLOTS-1:0] lowest_one(input logic [RSV_SLOTS-1:0] v);
        logic [RSV_SLOTS-1:0] r;
        r = '0;
        for (int i = RSV_SLOTS - 1; i >= 0; i--) begin
            if (v[i]) r = '0 | (RSV_SLOTS'(1) << i);
        end
        return r;
    endfunction

endpackage

// File: rtl/resv_lookup.sv
// Compares one requester ID against the valid slots of one block row.
// Assumes: the row has already been masked for any clear applied earlier in the cycle.
module resv_lookup
    import resv_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic [RSV_SLOTS-1:0]           row_vld,
    input  logic [RSV_SLOTS-1:0][ID_W-1:0] row_id,
    input  logic [ID_W-1:0]                req_id,
    output logic                           hit
);

    logic [RSV_SLOTS-1:0] match;

    // Per-slot match of a valid entry against the requester.
    for (genvar s = 0; s < RSV_SLOTS; s++) begin : g_cmp
        assign match[s] = row_vld[s] && (row_id[s] == req_id);
    end

    // Any matching slot means the requester holds a reservation.
    always_comb hit = |match;

endmodule

// File: rtl/resv_table.sv
// Reservation storage: a valid bit and requester ID per slot, per block.
// Assumes: per cycle, a block clear is applied before the single slot set.
module resv_table
    import resv_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int ID_W       = 4,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic [NUM_BLOCKS-1:0]                          clr,
    input  logic                                           set_en,
    input  logic [BLK_W-1:0]                               set_blk,
    input  logic [RSV_SLOTS-1:0]                           set_slot,
    input  logic [ID_W-1:0]                                set_id,
    output logic [NUM_BLOCKS-1:0][RSV_SLOTS-1:0]           tbl_vld,
    output logic [NUM_BLOCKS-1:0][RSV_SLOTS-1:0][ID_W-1:0] tbl_id
);

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        logic                 set_here;
        logic [RSV_SLOTS-1:0] vld_nxt;

        // Set applies to this block only when addressed.
        always_comb set_here = set_en && (set_blk == BLK_W'(b));

        // Next valid vector: clear first, then add the chosen slot.
        always_comb vld_nxt = (clr[b] ? '0 : tbl_vld[b]) | (set_here ? set_slot : '0);

        // Valid bits are reset; IDs only matter where valid.
        always_ff @(posedge clk) begin
            if (!rst_n) tbl_vld[b] <= '0;
            else        tbl_vld[b] <= vld_nxt;
        end

        // Record the requester in the newly taken slot.
        for (genvar s = 0; s < RSV_SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n)                      tbl_id[b][s] <= '0;
                else if (set_here && set_slot[s]) tbl_id[b][s] <= set_id;
            end
        end
    end

endmodule

// File: rtl/resv_tracker.sv
// Top of the bounded reservation tracker. It takes one write, one
// store-conditional and one load-linked per cycle and applies them in that order.
// Responses are registered and appear one cycle after the request.
// Assumes: block indices are below NUM_BLOCKS.
module resv_tracker
    import resv_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int ID_W       = 4,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_vld,
    input  logic [BLK_W-1:0] wr_blk,
    input  logic             sc_vld,
    input  logic [BLK_W-1:0] sc_blk,
    input  logic [ID_W-1:0]  sc_id,
    input  logic             ll_vld,
    input  logic [BLK_W-1:0] ll_blk,
    input  logic [ID_W-1:0]  ll_id,
    output logic             sc_rsp_vld,
    output logic             sc_rsp_ok,
    output logic             ll_rsp_vld,
    output logic             ll_rsp_granted
);

    logic [NUM_BLOCKS-1:0][RSV_SLOTS-1:0]           tbl_vld;
    logic [NUM_BLOCKS-1:0][RSV_SLOTS-1:0][ID_W-1:0] tbl_id;
    logic [NUM_BLOCKS-1:0]                          clr;

    logic                 sc_row_wiped;
    logic [RSV_SLOTS-1:0] sc_row_vld;
    logic                 sc_hit;
    logic                 sc_win;

    logic                 ll_row_wiped;
    logic [RSV_SLOTS-1:0] ll_row_vld;
    logic [RSV_SLOTS-1:0] ll_free;
    logic                 ll_hit;
    logic                 ll_take;
    logic                 ll_grant;

    // Store-conditional sees its row after a same-cycle write clear.
    always_comb begin
        sc_row_wiped = wr_vld && (wr_blk == sc_blk);
        sc_row_vld   = sc_row_wiped ? '0 : tbl_vld[sc_blk];
    end

    resv_lookup #(.ID_W(ID_W)) u_sc_lookup (
        .row_vld (sc_row_vld),
        .row_id  (tbl_id[sc_blk]),
        .req_id  (sc_id),
        .hit     (sc_hit)
    );

    // A store-conditional wins when its requester still holds a slot.
    always_comb sc_win = sc_vld && sc_hit;

    // Load-linked sees its row after the write and a winning store-conditional.
    always_comb begin
        ll_row_wiped = (wr_vld && (wr_blk == ll_blk)) || (sc_win && (sc_blk == ll_blk));
        ll_row_vld   = ll_row_wiped ? '0 : tbl_vld[ll_blk];
        ll_free      = lowest_one(~ll_row_vld);
    end

    resv_lookup #(.ID_W(ID_W)) u_ll_lookup (
        .row_vld (ll_row_vld),
        .row_id  (tbl_id[ll_blk]),
        .req_id  (ll_id),
        .hit     (ll_hit)
    );

    // Existing holders keep their slot; newcomers need a free one.
    always_comb begin
        ll_take  = ll_vld && !ll_hit && (|ll_free);
        ll_grant = ll_vld && (ll_hit || (|ll_free));
    end

    // Per-block clear from a write or a winning store-conditional.
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_clr
        assign clr[b] = (wr_vld && (wr_blk == BLK_W'(b))) ||
                        (sc_win && (sc_blk == BLK_W'(b)));
    end

    resv_table #(.NUM_BLOCKS(NUM_BLOCKS), .ID_W(ID_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .set_en   (ll_take),
        .set_blk  (ll_blk),
        .set_slot (ll_free),
        .set_id   (ll_id),
        .tbl_vld  (tbl_vld),
        .tbl_id   (tbl_id)
    );

    // Register the responses for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_rsp_vld     <= 1'b0;
            sc_rsp_ok      <= 1'b0;
            ll_rsp_vld     <= 1'b0;
            ll_rsp_granted <= 1'b0;
        end else begin
            sc_rsp_vld     <= sc_vld;
            sc_rsp_ok      <= sc_win;
            ll_rsp_vld     <= ll_vld;
            ll_rsp_granted <= ll_grant;
        end
    end

endmodule

// File: rtl/resv_tracker_chk.sv
// Property checker for resv_tracker, attached by bind below.
// Assumes: it observes the top's ports and its internal store-conditional win.
module resv_tracker_chk #(
    parameter int NUM_BLOCKS = 8,
    parameter int ID_W       = 4,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_vld,
    input logic [BLK_W-1:0] wr_blk,
    input logic             sc_vld,
    input logic [BLK_W-1:0] sc_blk,
    input logic [ID_W-1:0]  sc_id,
    input logic             ll_vld,
    input logic [BLK_W-1:0] ll_blk,
    input logic [ID_W-1:0]  ll_id,
    input logic             sc_win,
    input logic             sc_rsp_vld,
    input logic             sc_rsp_ok,
    input logic             ll_rsp_vld,
    input logic             ll_rsp_granted
);

    logic unused_ok;
    always_comb unused_ok = ^{sc_id, ll_id};

    a_r1_sc_echo: assert property (@(posedge clk) disable iff (!rst_n)
        sc_vld |=> sc_rsp_vld);
    a_r1_sc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_vld |=> !sc_rsp_vld);
    a_r1_ll_echo: assert property (@(posedge clk) disable iff (!rst_n)
        ll_vld |=> ll_rsp_vld);
    a_r1_ll_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ll_vld |=> !ll_rsp_vld);
    a_r3_grant_has_vld: assert property (@(posedge clk) disable iff (!rst_n)
        ll_rsp_granted |-> ll_rsp_vld);
    a_r5_ok_has_vld: assert property (@(posedge clk) disable iff (!rst_n)
        sc_rsp_ok |-> sc_rsp_vld);
    a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_win && !(ll_vld && (ll_blk == sc_blk))) |=> !(sc_win && (sc_blk == $past(sc_blk))));
    a_r8_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && sc_vld && (wr_blk == sc_blk)) |=> !sc_rsp_ok);
    a_r8_ll_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_vld && wr_vld && (wr_blk == ll_blk)) |=> ll_rsp_granted);
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sc_rsp_vld && !ll_rsp_vld && !sc_rsp_ok && !ll_rsp_granted));

endmodule

bind resv_tracker resv_tracker_chk #(.NUM_BLOCKS(NUM_BLOCKS), .ID_W(ID_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_vld         (wr_vld),
    .wr_blk         (wr_blk),
    .sc_vld         (sc_vld),
    .sc_blk         (sc_blk),
    .sc_id          (sc_id),
    .ll_vld         (ll_vld),
    .ll_blk         (ll_blk),
    .ll_id          (ll_id),
    .sc_win         (sc_win),
    .sc_rsp_vld     (sc_rsp_vld),
    .sc_rsp_ok      (sc_rsp_ok),
    .ll_rsp_vld     (ll_rsp_vld),
    .ll_rsp_granted (ll_rsp_granted)
);

// File: tb/tb_resv_tracker.sv
// Self-checking bench: directed corners, then seeded random traffic,
// compared against a behavioural reservation model.
module tb_resv_tracker;

    localparam int NB    = 8;
    localparam int IW    = 4;
    localparam int BW    = $clog2(NB);
    localparam int SLOTS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_vld = 1'b0, sc_vld = 1'b0, ll_vld = 1'b0;
    logic [BW-1:0] wr_blk = '0, sc_blk = '0, ll_blk = '0;
    logic [IW-1:0] sc_id = '0, ll_id = '0;
    logic          sc_rsp_vld, sc_rsp_ok, ll_rsp_vld, ll_rsp_granted;

    int n_chk = 0;
    int n_bad = 0;

    bit m_v  [NB][SLOTS];
    int m_id [NB][SLOTS];

    always #2 clk = ~clk;

    resv_tracker #(.NUM_BLOCKS(NB), .ID_W(IW)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_vld(wr_vld), .wr_blk(wr_blk),
        .sc_vld(sc_vld), .sc_blk(sc_blk), .sc_id(sc_id),
        .ll_vld(ll_vld), .ll_blk(ll_blk), .ll_id(ll_id),
        .sc_rsp_vld(sc_rsp_vld), .sc_rsp_ok(sc_rsp_ok),
        .ll_rsp_vld(ll_rsp_vld), .ll_rsp_granted(ll_rsp_granted)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_clear_all();
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < SLOTS; s++) m_v[b][s] = 1'b0;
    endtask

    task automatic model_clear(input int b);
        for (int s = 0; s < SLOTS; s++) m_v[b][s] = 1'b0;
    endtask

    function automatic bit model_holds(input int b, input int id);
        for (int s = 0; s < SLOTS; s++)
            if (m_v[b][s] && m_id[b][s] == id) return 1'b1;
        return 1'b0;
    endfunction

    // One cycle of traffic; responses checked one edge later.
    task automatic step(input bit wv, input int wb, input bit sv, input int sb, input int si,
                        input bit lv, input int lb, input int li, input string tag);
        bit e_sc, e_ll, placed;
        wr_vld = wv; wr_blk = BW'(wb);
        sc_vld = sv; sc_blk = BW'(sb); sc_id = IW'(si);
        ll_vld = lv; ll_blk = BW'(lb); ll_id = IW'(li);
        e_sc = 1'b0; e_ll = 1'b0;
        if (wv) model_clear(wb);
        if (sv) begin
            e_sc = model_holds(sb, si);
            if (e_sc) model_clear(sb);
        end
        if (lv) begin
            if (model_holds(lb, li)) e_ll = 1'b1;
            else begin
                placed = 1'b0;
                for (int s = 0; s < SLOTS; s++) begin
                    if (!placed && !m_v[lb][s]) begin
                        m_v[lb][s] = 1'b1; m_id[lb][s] = li; placed = 1'b1;
                    end
                end
                e_ll = placed;
            end
        end
        @(posedge clk); #1;
        check(sc_rsp_vld, sv, {tag, " R1 sc_vld"});
        check(sc_rsp_ok, e_sc, {tag, " sc_ok"});
        check(ll_rsp_vld, lv, {tag, " R1 ll_vld"});
        check(ll_rsp_granted, e_ll, {tag, " ll_grant"});
        @(negedge clk);
        wr_vld = 1'b0; sc_vld = 1'b0; ll_vld = 1'b0;
    endtask

    task automatic ll(input int b, input int id, input string tag);
        step(0, 0, 0, 0, 0, 1, b, id, tag);
    endtask

    task automatic sc(input int b, input int id, input string tag);
        step(0, 0, 1, b, id, 0, 0, 0, tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        wr_vld = 1'b0; sc_vld = 1'b0; ll_vld = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(sc_rsp_vld, 1'b0, {tag, " R9 reset sc_vld"});
        check(sc_rsp_ok, 1'b0, {tag, " R9 reset sc_ok"});
        check(ll_rsp_vld, 1'b0, {tag, " R9 reset ll_vld"});
        check(ll_rsp_granted, 1'b0, {tag, " R9 reset ll_grant"});
        @(negedge clk);
        rst_n = 1'b1;
        model_clear_all();
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_clear_all();
        do_reset("start");

        // R2 / R5 / R6: basic pair, then the reservation is consumed.
        ll(0, 1, "R2 first ll");
        sc(0, 1, "R5 held sc");
        sc(0, 1, "R6 second sc after win");
        sc(0, 2, "R5 never reserved");

        // R3 / R4: fill a block, refuse a fifth, repeat holder keeps slot.
        for (int i = 1; i <= 4; i++) ll(1, i, "R2 fill");
        ll(1, 5, "R3 fifth refused");
        sc(1, 5, "R3 refused sc fails");
        ll(1, 2, "R4 repeat holder");
        ll(1, 6, "R4 no extra slot used");
        sc(1, 3, "R3 holders intact");
        sc(1, 4, "R6 others cleared");

        // R4: repeats do not consume slots on a partly filled block.
        for (int i = 1; i <= 3; i++) ll(6, i, "R4 partial fill");
        ll(6, 1, "R4 repeat a");
        ll(6, 1, "R4 repeat b");
        ll(6, 9, "R4 fourth still fits");
        ll(6, 10, "R4 now full");

        // R7: write clears only its own block.
        ll(2, 7, "R7 setup");
        step(1, 3, 0, 0, 0, 0, 0, 0, "R7 write other");
        sc(2, 7, "R7 other block kept");
        ll(2, 7, "R7 setup again");
        step(1, 2, 0, 0, 0, 0, 0, 0, "R7 write own");
        sc(2, 7, "R7 own block cleared");

        // R8: write, store-conditional and load-linked together on one block.
        ll(4, 8, "R8 setup");
        step(1, 4, 1, 4, 8, 1, 4, 9, "R8 write beats sc");
        sc(4, 9, "R8 ll after write held");
        for (int i = 1; i <= 4; i++) ll(5, i, "R8 fill");
        step(0, 0, 1, 5, 1, 1, 5, 9, "R8 ll after sc win");
        sc(5, 9, "R8 late ll holds");

        // R1: idle cycle gives no responses.
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");

        // R9: reset drops live reservations.
        ll(7, 1, "R9 setup");
        do_reset("mid");
        sc(7, 1, "R9 cleared by reset");

        // Seeded random traffic on a few blocks to force saturation.
        void'($urandom(32'd2024));
        for (int n = 0; n < 4000; n++) begin
            bit wv, sv, lv;
            wv = ($urandom % 16) == 0;
            sv = ($urandom % 3) == 0;
            lv = ($urandom % 2) == 0;
            step(wv, $urandom % 3, sv, $urandom % 3, $urandom % 6,
                 lv, $urandom % 3, $urandom % 6, "rand R5");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule